// File: doc/BRIEF.md
# Greyscale Frame Scan-Out Engine

This block turns a packed 4-bit-per-pixel greyscale picture memory into a magnified stream of colour pixels for a host display. Every memory byte carries two pixels: the left one in the high nibble, the right one in the low nibble. Each pixel is sent out four times in a row, and each picture line is sent four times over. With the default sizes, a 128 x 64 visible picture becomes a 512 x 256 stream. The memory holds more rows than are shown, and only the leading rows are ever read.

A frame starts only when the host raises a redraw request. The engine then latches the chosen colour format and walks the picture line by line. It fetches one byte at a time from a synchronous memory that has one cycle of read latency. Each output line is rebuilt by reading its memory row again. Pixels leave over a valid/ready handshake that carries start-of-frame and end-of-line flags. A one-cycle acknowledge marks the end of the frame.

Top module: `gsc_scanout`

## Requirements
- R1: While reset is low, and right after it, pix_valid, rd_en and redraw_ack are all 0. A reset in mid-frame abandons the frame.
- R2: With no redraw request pending, the engine issues no memory reads and presents no pixels.
- R3: Line y of a frame reads addresses row*ROW_STRIDE + b, where row = y / MAG and b runs 0..LINE_BYTES-1. No address at or above VIS_ROWS*ROW_STRIDE is ever read.
- R4: Within a byte, bits [7:4] give the left pixel and bits [3:0] give the right pixel.
- R5: Each pixel is output MAG times in succession and each line MAG times, so a frame holds VIS_ROWS*MAG lines of 2*MAG*LINE_BYTES pixels.
- R6: Format code 2 (24-bit) gives pix_data = {8'h00, n, n, n}, where n = {i, i} for grey level i.
- R7: Format code 3 (32-bit) gives pix_data = {8'hFF, n, n, n}, where n = {i, i}.
- R8: Format code 0 (15-bit) gives pix_data[14:0] = {c, c, c}, where c = 2*i + (i>>3) on 5 bits. The upper bits are 0.
- R9: Format code 1 (16-bit) gives pix_data[15:0] = {c, g, c}, where g = 2*c + (i>>3) on 6 bits. The upper bits are 0.
- R10: pix_sof is 1 only on the first pixel of a frame. pix_eol is 1 exactly on the last pixel of each output line.
- R11: While pix_valid is 1 and pix_ready is 0, pix_valid stays 1 and pix_data, pix_sof and pix_eol hold their values.
- R12: redraw_ack is a one-cycle pulse in the cycle after the frame's last pixel is accepted. The format code is sampled at frame start, and any change during the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redraw_req | input | 1 | Redraw pending; held by the host until acknowledged |
| fmt_sel | input | 2 | Output colour format code |
| redraw_ack | output | 1 | One-cycle end-of-frame acknowledge |
| rd_en | output | 1 | Picture memory read strobe |
| rd_addr | output | AW | Picture memory byte address |
| rd_data | input | 8 | Read byte, valid the cycle after rd_en |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_data | output | 32 | Expanded colour pixel |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of an output line |

## Verification
The assertions assume four things about the environment:
- the memory returns the addressed byte exactly one cycle after rd_en;
- the host keeps redraw_req high until it sees redraw_ack, and drops it in that acknowledge cycle;
- pix_ready may toggle freely;
- fmt_sel may change at any time.

The stimulus keeps within these assumptions. A bench memory model answers with a one-cycle delay, and the host drops the request on the acknowledge. The sink's ready line is driven by several patterns: always ready, alternating, pseudo-random and mostly stalled. The format code is also changed in the middle of a frame.

// File: rtl/gsc_pkg.sv
// Shared types for the greyscale scan-out engine.
// Assumes a 2-bit format code driven by the host.
package gsc_pkg;
    typedef enum logic [1:0] {
        FMT_RGB555 = 2'd0,
        FMT_RGB565 = 2'd1,
        FMT_RGB888 = 2'd2,
        FMT_XRGB   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_EMIT  = 2'd3
    } scan_st_e;
endpackage

// File: rtl/gsc_expand.sv
// Grey-to-colour expander: maps a 4-bit grey level to a 32-bit pixel
// in the selected format by bit replication. Purely combinational.
// Assumes fmt is held stable by the caller for a whole frame.
module gsc_expand
    import gsc_pkg::*;
(
    input  logic [3:0]  grey,
    input  fmt_e        fmt,
    output logic [31:0] pixel
);
    logic [4:0] c5;
    logic [5:0] g6;
    logic [7:0] c8;

    // Channel widening: 5-bit, 6-bit and 8-bit replicated levels.
    always_comb begin
        c5 = {grey, grey[3]};
        g6 = {c5, grey[3]};
        c8 = {grey, grey};
    end

    // Pack the channels for the chosen format.
    always_comb begin
        unique case (fmt)
            FMT_RGB555: pixel = {17'd0, c5, c5, c5};
            FMT_RGB565: pixel = {16'd0, c5, g6, c5};
            FMT_RGB888: pixel = {8'h00, c8, c8, c8};
            default:    pixel = {8'hFF, c8, c8, c8};
        endcase
    end
endmodule

// File: rtl/gsc_walker.sv
// Frame position walker: tracks horizontal repeat, nibble, byte, vertical
// repeat and memory row. It advances one pixel per step and wraps to the
// frame origin after the last pixel.
// Assumes step is only raised while a pixel is being accepted.
module gsc_walker #(
    parameter int LINE_BYTES = 64,
    parameter int VIS_ROWS   = 64,
    parameter int MAG        = 4,
    localparam int HW = (MAG > 1) ? $clog2(MAG) : 1,
    localparam int BW = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1,
    localparam int RW = (VIS_ROWS > 1) ? $clog2(VIS_ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic          nib_lo,
    output logic [RW-1:0] row,
    output logic [BW-1:0] col_byte,
    output logic          byte_done,
    output logic          frame_done,
    output logic          first,
    output logic          line_end
);
    logic [HW-1:0] hrep_q;
    logic [HW-1:0] vrep_q;
    logic          nib_q;
    logic [BW-1:0] byte_q;
    logic [RW-1:0] row_q;

    logic hrep_last, vrep_last, byte_last, row_last;

    // Terminal-count decode for each counter.
    always_comb begin
        hrep_last = (hrep_q == HW'(MAG - 1));
        vrep_last = (vrep_q == HW'(MAG - 1));
        byte_last = (byte_q == BW'(LINE_BYTES - 1));
        row_last  = (row_q == RW'(VIS_ROWS - 1));
    end

    // Nested counters: hrep -> nibble -> byte -> vrep -> row.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hrep_q <= '0;
            vrep_q <= '0;
            nib_q  <= 1'b0;
            byte_q <= '0;
            row_q  <= '0;
        end else if (step) begin
            if (!hrep_last) begin
                hrep_q <= hrep_q + 1'b1;
            end else begin
                hrep_q <= '0;
                nib_q  <= ~nib_q;
                if (nib_q) begin
                    if (!byte_last) begin
                        byte_q <= byte_q + 1'b1;
                    end else begin
                        byte_q <= '0;
                        if (!vrep_last) begin
                            vrep_q <= vrep_q + 1'b1;
                        end else begin
                            vrep_q <= '0;
                            row_q  <= row_last ? '0 : row_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Position flags for the controller and the output markers.
    always_comb begin
        nib_lo     = nib_q;
        row        = row_q;
        col_byte   = byte_q;
        byte_done  = nib_q && hrep_last;
        line_end   = byte_done && byte_last;
        frame_done = line_end && vrep_last && row_last;
        first      = (hrep_q == '0) && !nib_q && (byte_q == '0)
                     && (vrep_q == '0) && (row_q == '0);
    end

    // R5: the byte being replicated does not move until both nibbles are spent.
    assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !byte_done && !clear) |=> $stable(col_byte));
endmodule

// File: rtl/gsc_scanout.sv
// Greyscale scan-out engine top. On a redraw request it latches the format
// and then fetches one byte per pixel pair. It emits each nibble MAG times
// and re-reads every memory row MAG times. The request is acknowledged
// after the last pixel.
// Assumes a synchronous memory with one cycle of read latency, and a host
// that holds redraw_req until redraw_ack.
module gsc_scanout
    import gsc_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int VIS_ROWS   = 64,
    parameter int MEM_ROWS   = 80,
    parameter int ROW_STRIDE = 64,
    parameter int MAG        = 4,
    localparam int AW = $clog2(MEM_ROWS * ROW_STRIDE),
    localparam int BW = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1,
    localparam int RW = (VIS_ROWS > 1) ? $clog2(VIS_ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redraw_req,
    input  logic [1:0]    fmt_sel,
    output logic          redraw_ack,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          pix_valid,
    input  logic          pix_ready,
    output logic [31:0]   pix_data,
    output logic          pix_sof,
    output logic          pix_eol
);
    scan_st_e      state_q;
    fmt_e          fmt_q;
    logic [7:0]    byte_q;
    logic          ack_q;

    logic          w_clear, w_step, nib_lo, byte_done, frame_done, first, line_end;
    logic [RW-1:0] row;
    logic [BW-1:0] col_byte;
    logic [3:0]    grey;

    // Walker control: hold at origin when idle, advance on each accepted pixel.
    always_comb begin
        w_clear = (state_q == ST_IDLE);
        w_step  = (state_q == ST_EMIT) && pix_ready;
    end

    gsc_walker #(
        .LINE_BYTES(LINE_BYTES),
        .VIS_ROWS  (VIS_ROWS),
        .MAG       (MAG)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (w_clear),
        .step      (w_step),
        .nib_lo    (nib_lo),
        .row       (row),
        .col_byte  (col_byte),
        .byte_done (byte_done),
        .frame_done(frame_done),
        .first     (first),
        .line_end  (line_end)
    );

    // Sequencer: idle -> fetch -> load -> emit, and back to fetch per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= FMT_RGB555;
            byte_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (redraw_req && !ack_q) begin
                        fmt_q   <= fmt_e'(fmt_sel);
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_LOAD;
                ST_LOAD: begin
                    byte_q  <= rd_data;
                    state_q <= ST_EMIT;
                end
                default: begin
                    if (pix_ready && byte_done) begin
                        if (frame_done) begin
                            state_q <= ST_IDLE;
                            ack_q   <= 1'b1;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
            endcase
        end
    end

    // Memory address: displayed row at its stride plus byte within the line.
    always_comb begin
        rd_en   = (state_q == ST_FETCH);
        rd_addr = AW'(row) * AW'(ROW_STRIDE) + AW'(col_byte);
    end

    // Nibble select: high nibble is the left pixel.
    always_comb begin
        grey = nib_lo ? byte_q[3:0] : byte_q[7:4];
    end

    gsc_expand u_expand (
        .grey (grey),
        .fmt  (fmt_q),
        .pixel(pix_data)
    );

    // Stream outputs and frame markers.
    always_comb begin
        pix_valid  = (state_q == ST_EMIT);
        pix_sof    = pix_valid && first;
        pix_eol    = pix_valid && line_end;
        redraw_ack = ack_q;
    end

    // R11: a stalled pixel stays on the bus unchanged.
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)
                                       && $stable(pix_sof) && $stable(pix_eol)));

    // R12: the acknowledge never lasts more than one cycle.
    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        redraw_ack |=> !redraw_ack);

    // R12: the latched format cannot move while pixels of a frame are out.
    assert_fmt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_sof) |-> $stable(fmt_q));

    // R3: reads stay inside the displayed rows.
    assert_rd_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < VIS_ROWS * ROW_STRIDE));

    // R2: without a request an idle engine stays quiet.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redraw_req && !pix_valid && !rd_en) |=> !rd_en);
endmodule

// File: tb/gsc_scanout_tb.sv
// Self-checking bench for gsc_scanout on a reduced picture size.
module gsc_scanout_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LB     = 4;
    localparam int VR     = 3;
    localparam int MAG    = 4;
    localparam int STRIDE = 64;
    localparam int MEMR   = 80;
    localparam int AW     = $clog2(MEMR * STRIDE);
    localparam int W      = LB * 2 * MAG;
    localparam int H      = VR * MAG;
    localparam int FRAME_PIX = W * H;
    localparam int NVEC   = 5;
    // Table rows: {format code, ready pattern}.
    localparam logic [3:0] VEC [NVEC] = '{4'h0, 4'h5, 4'hA, 4'hF, 4'h9};

    logic          clk, rst_n, redraw_req, redraw_ack, rd_en;
    logic [1:0]    fmt_sel;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          pix_valid, pix_ready, pix_sof, pix_eol;
    logic [31:0]   pix_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int px = 0, py = 0, acc = 0, sofs = 0, eols = 0;
    int rdy_mode = 0, exp_fmt = 0;
    bit hold = 0, prev_sof = 0, prev_eol = 0;
    logic [31:0] prev_pix = '0;
    logic [15:0] lfsr = 16'hACE1;

    gsc_scanout #(
        .LINE_BYTES(LB), .VIS_ROWS(VR), .MEM_ROWS(MEMR),
        .ROW_STRIDE(STRIDE), .MAG(MAG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .redraw_req(redraw_req), .fmt_sel(fmt_sel),
        .redraw_ack(redraw_ack), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] memval(int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    function automatic logic [31:0] exp_pix(int f, int i);
        int c = 2 * i + (i >> 3);
        int g = 2 * c + (i >> 3);
        int n = i * 17;
        case (f)
            0: return 32'((c << 10) | (c << 5) | c);
            1: return 32'((c << 11) | (g << 5) | c);
            2: return 32'((n << 16) | (n << 8) | n);
            default: return 32'hFF000000 | 32'((n << 16) | (n << 8) | n);
        endcase
    endfunction

    function automatic string fmt_tag(int f);
        case (f)
            0: return "R8";
            1: return "R9";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one cycle of read latency.
    always @(posedge clk) if (rd_en) rd_data <= memval(int'(rd_addr));

    // Sink, monitor and watchdog, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: pix_ready = 1'b1;
            1: pix_ready = ~pix_ready;
            2: pix_ready = lfsr[0];
            default: pix_ready = (cyc % 4 == 0);
        endcase
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst_n && rd_en)
            check(int'(rd_addr) < VR * STRIDE, "R3 read window", 32'(rd_addr), 32'(VR * STRIDE));
        if (rst_n && pix_valid) begin
            if (hold)
                check(pix_data == prev_pix && pix_sof == prev_sof && pix_eol == prev_eol,
                      "R11 stall hold", pix_data, prev_pix);
            if (pix_ready) begin
                logic [7:0] b;
                int gv;
                b  = memval((py / MAG) * STRIDE + px / (2 * MAG));
                gv = ((px / MAG) % 2 == 0) ? int'(b[7:4]) : int'(b[3:0]);
                check(pix_data == exp_pix(exp_fmt, gv),
                      {"R4 R5 ", fmt_tag(exp_fmt), " pixel"}, pix_data, exp_pix(exp_fmt, gv));
                check(pix_sof == (px == 0 && py == 0), "R10 sof", 32'(pix_sof), 32'(px == 0 && py == 0));
                check(pix_eol == (px == W - 1), "R10 eol", 32'(pix_eol), 32'(px == W - 1));
                if (pix_sof) sofs++;
                if (pix_eol) eols++;
                acc++;
                px++;
                if (px == W) begin px = 0; py++; end
            end
            hold = !pix_ready;
            prev_pix = pix_data;
            prev_sof = pix_sof;
            prev_eol = pix_eol;
        end else begin
            if (hold && rst_n) check(1'b0, "R11 valid dropped", 32'(pix_valid), 32'd1);
            hold = 0;
        end
        if (cyc > 150000) begin
            check(1'b0, "watchdog", 32'(cyc), 32'd150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_frame(input int f, input int mode, input bit chg);
        bit got = 0;
        @(negedge clk);
        rdy_mode = mode;
        exp_fmt = f;
        px = 0; py = 0; acc = 0; sofs = 0; eols = 0;
        fmt_sel = 2'(f);
        redraw_req = 1'b1;
        if (chg) begin
            for (int t = 0; t < 2000 && acc == 0; t++) @(negedge clk);
            fmt_sel = 2'(f ^ 2); // R12: mid-frame change must be ignored
        end
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (redraw_ack) begin got = 1; break; end
        end
        redraw_req = 1'b0;
        check(got, "R12 ack seen", 32'(got), 32'd1);
        check(acc == FRAME_PIX, "R5 pixel count", 32'(acc), 32'(FRAME_PIX));
        check(sofs == 1, "R10 sof count", 32'(sofs), 32'd1);
        check(eols == H, "R10 eol count", 32'(eols), 32'(H));
        @(negedge clk);
        check(!redraw_ack, "R12 ack pulse width", 32'(redraw_ack), 32'd0);
    endtask

    initial begin
        bit quiet;
        rst_n = 1'b0; redraw_req = 1'b0; fmt_sel = 2'd0; pix_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!pix_valid && !rd_en && !redraw_ack, "R1 reset state",
              {29'd0, pix_valid, rd_en, redraw_ack}, 32'd0);
        rst_n = 1'b1;
        // R2: no request, nothing happens.
        quiet = 1;
        repeat (12) begin @(negedge clk); if (pix_valid || rd_en) quiet = 0; end
        check(quiet, "R2 idle without request", 32'(quiet), 32'd1);
        // Table walk: each format under a different sink pattern.
        for (int k = 0; k < NVEC; k++) run_frame(int'(VEC[k][3:2]), int'(VEC[k][1:0]), 1'b0);
        // R2 after a frame: request dropped, engine stays quiet.
        quiet = 1;
        repeat (12) begin @(negedge clk); if (pix_valid || rd_en) quiet = 0; end
        check(quiet, "R2 idle after ack", 32'(quiet), 32'd1);
        // R12: format change in mid-frame.
        run_frame(1, 0, 1'b1);
        // R1: reset in the middle of a frame.
        @(negedge clk);
        rdy_mode = 0; px = 0; py = 0; acc = 0; exp_fmt = 2; fmt_sel = 2'd2;
        redraw_req = 1'b1;
        for (int t = 0; t < 2000 && acc < 20; t++) @(negedge clk);
        rst_n = 1'b0; redraw_req = 1'b0;
        @(negedge clk);
        check(!pix_valid && !rd_en && !redraw_ack, "R1 mid-frame reset",
              {29'd0, pix_valid, rd_en, redraw_ack}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(3, 2, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule